// File: doc/BRIEF.md
# ATA Multi-Sector PIO Transfer Sequencer

This block drives the handshake flags of a disk-style task-file interface while a multi-sector programmed-I/O read or write runs. On an accepted command it loads a sector count and a starting sector address. It then steps through the sectors one buffer at a time. For each sector it asks the storage core to fill or drain the single sector buffer, and it opens a 256-word host data-port window. It raises the busy flag, the data-request flag and a one-cycle interrupt pulse in the order the host software expects. As sectors complete, the sector-count and current-address outputs track the progress of the command.

A read asks the core to fill the buffer, then opens the window with an interrupt. A write opens the first window silently. After each host fill, the block asks the core to program the sector, and it reports completion only when the core is done. If the core reports an error, the command stops at once. The address and count outputs are left showing the failing sector and the number of sectors not yet moved.

The host data port is a valid/ready stream with no data path inside the block. Each handshake (`word_valid` and `word_ready` both high at a clock edge) counts as one 16-bit access. `word_ready` is high only while the data-request flag is set and busy is clear. The host may hold `word_valid` high or drop it on any cycle, and no access is counted while `word_ready` is low.

Top module: `ata_xfer_seq`

## Requirements
- R1: After reset, busy, data request, error, interrupt, core request and word_ready are all 0, and the sector count and current address read 0.
- R2: A command count of 1 to 255 moves that many sectors, and a count of 0 moves 256 sectors.
- R3: On a read, the data-request flag of every sector rises in the same cycle as a one-cycle interrupt pulse. This happens only after the core reports the buffer filled. No interrupt follows the last sector of a successful read.
- R4: On a write, the first sector's data-request rises with no interrupt. Each later sector's data-request rises together with an interrupt pulse.
- R5: On a write, the clock edge that accepts a sector's final word clears data request and sets busy. Busy stays set until the core reports the sector programmed. After the last sector, busy then clears together with an interrupt pulse.
- R6: Data request drops on the clock edge after exactly 256 host handshakes. Gaps in `word_valid` neither add nor lose accesses.
- R7: Each time data request rises, busy stays set for exactly SETTLE cycles (default 2) and then clears while data request stays set.
- R8: After each successful sector, the current address increases by 1 and the remaining count decreases by 1. The count output shows the remaining count modulo 256, so it reads 0 at the end.
- R9: When the core reports an error, busy and data request clear, the error flag sets and one interrupt pulse fires, all in the same cycle. The address keeps the failing sector, and the count keeps the sectors not yet transferred, the failing one included.
- R10: The error flag clears on the edge that accepts the next command.
- R11: A command strobe while busy or data request is set is ignored. Address, count and direction do not change, and the running command finishes as if the strobe had not come.
- R12: The core request output pulses exactly once per sector operation: once per read-buffer fill and once per write-buffer program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_write | input | 1 | 1 = write command, 0 = read command |
| cmd_count | input | CNT_W | Sector count, 0 means 256 |
| cmd_addr | input | ADDR_W | Starting sector address |
| word_valid | input | 1 | Host data-port access offered |
| word_ready | output | 1 | Data-port window open |
| core_req | output | 1 | One-cycle request to fill or program the buffer |
| xfer_is_write | output | 1 | Direction of the current command |
| core_done | input | 1 | Core finished the requested sector |
| core_err | input | 1 | Core failed the requested sector |
| stat_bsy | output | 1 | Busy status flag |
| stat_drq | output | 1 | Data-request status flag |
| stat_err | output | 1 | Error status flag |
| irq | output | 1 | One-cycle interrupt pulse |
| sector_count | output | CNT_W | Remaining sector count |
| cur_addr | output | ADDR_W | Current sector address |

## Verification
The assertions assume the core raises `core_done` or `core_err` only while a request is outstanding, as a one-cycle pulse, and never both together. They also assume a new request is not issued before the previous one is answered. The bench's core model follows this rule: it answers each observed `core_req` with a single pulse after a fixed latency, and it picks the error pulse only for the sector chosen to fail. The host driver may offer `word_valid` at any time, including gappy patterns, because the block gates every access with `word_ready`.

// File: rtl/ata_xfer_pkg.sv
package ata_xfer_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_WAIT,
    ST_SETTLE,
    ST_XFER
  } seq_state_t;
endpackage

// File: rtl/xfer_word_ctr.sv
module xfer_word_ctr #(
  parameter int WORDS = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic hs,
  output logic last_word
);
  localparam int CW = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [CW-1:0] LAST = CW'(WORDS - 1);

  logic [CW-1:0] cnt;

  assign last_word = hs && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (hs) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  // R6
  wrap_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !clr && cnt == LAST) |=> (cnt == '0));
endmodule

// File: rtl/xfer_settle_tmr.sv
module xfer_settle_tmr #(
  parameter int SETTLE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic expire
);
  localparam int TW = $clog2(SETTLE + 1);

  logic [TW-1:0] cnt;

  assign expire = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (start) cnt <= TW'(SETTLE - 1);
    else if (run && cnt != '0) cnt <= cnt - 1'b1;
  end

  // R7
  settle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == TW'(SETTLE - 1)));
endmodule

// File: rtl/xfer_sector_trk.sv
module xfer_sector_trk #(
  parameter int ADDR_W = 28,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  output logic              last_sector,
  output logic [CNT_W-1:0]  cnt_reg,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [CNT_W:0] FULL = {1'b1, {CNT_W{1'b0}}};

  logic [CNT_W:0] remaining;

  assign last_sector = (remaining == (CNT_W+1)'(1));
  assign cnt_reg     = remaining[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remaining <= '0;
      addr      <= '0;
    end else if (load) begin
      remaining <= (load_cnt == '0) ? FULL : {1'b0, load_cnt};
      addr      <= load_addr;
    end else if (step) begin
      remaining <= remaining - 1'b1;
      addr      <= addr + 1'b1;
    end
  end

  // R2
  zero_means_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_cnt == '0) |=> (remaining == FULL));

  // R8
  step_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (remaining == $past(remaining) - 1'b1) &&
                        (addr == $past(addr) + 1'b1));
endmodule

// File: rtl/ata_xfer_seq.sv
module ata_xfer_seq
  import ata_xfer_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int CNT_W  = 8,
  parameter int WORDS  = 256,
  parameter int SETTLE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              word_valid,
  output logic              word_ready,
  output logic              core_req,
  output logic              xfer_is_write,
  input  logic              core_done,
  input  logic              core_err,
  output logic              stat_bsy,
  output logic              stat_drq,
  output logic              stat_err,
  output logic              irq,
  output logic [CNT_W-1:0]  sector_count,
  output logic [ADDR_W-1:0] cur_addr
);
  seq_state_t state, nxt;
  logic is_wr_q, err_q, irq_q, req_q;
  logic hs, last_word, last_sector, expire;
  logic go_settle, step, load, req, fire_irq, set_err;

  assign word_ready    = (state == ST_XFER);
  assign hs            = word_valid && word_ready;
  assign stat_drq      = (state == ST_SETTLE) || (state == ST_XFER);
  assign stat_bsy      = (state == ST_PREP) || (state == ST_WAIT) || (state == ST_SETTLE);
  assign stat_err      = err_q;
  assign irq           = irq_q;
  assign core_req      = req_q;
  assign xfer_is_write = is_wr_q;

  xfer_word_ctr #(.WORDS(WORDS)) u_words (
    .clk(clk), .rst_n(rst_n), .clr(load), .hs(hs), .last_word(last_word)
  );

  xfer_settle_tmr #(.SETTLE(SETTLE)) u_settle (
    .clk(clk), .rst_n(rst_n), .start(go_settle),
    .run(state == ST_SETTLE), .expire(expire)
  );

  xfer_sector_trk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .load(load), .load_cnt(cmd_count),
    .load_addr(cmd_addr), .step(step), .last_sector(last_sector),
    .cnt_reg(sector_count), .addr(cur_addr)
  );

  always_comb begin
    nxt       = state;
    go_settle = 1'b0;
    step      = 1'b0;
    load      = 1'b0;
    req       = 1'b0;
    fire_irq  = 1'b0;
    set_err   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (cmd_valid) begin
          load = 1'b1;
          if (cmd_write) nxt = ST_PREP;
          else begin
            nxt = ST_WAIT;
            req = 1'b1;
          end
        end
      end
      ST_PREP: begin
        nxt       = ST_SETTLE;
        go_settle = 1'b1;
      end
      ST_SETTLE: begin
        if (expire) nxt = ST_XFER;
      end
      ST_XFER: begin
        if (last_word) begin
          if (is_wr_q) begin
            nxt = ST_WAIT;
            req = 1'b1;
          end else begin
            step = 1'b1;
            if (last_sector) nxt = ST_IDLE;
            else begin
              nxt = ST_WAIT;
              req = 1'b1;
            end
          end
        end
      end
      ST_WAIT: begin
        if (core_err) begin
          set_err  = 1'b1;
          fire_irq = 1'b1;
          nxt      = ST_IDLE;
        end else if (core_done) begin
          fire_irq = 1'b1;
          if (is_wr_q) begin
            step = 1'b1;
            if (last_sector) nxt = ST_IDLE;
            else begin
              nxt       = ST_SETTLE;
              go_settle = 1'b1;
            end
          end else begin
            nxt       = ST_SETTLE;
            go_settle = 1'b1;
          end
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      is_wr_q <= 1'b0;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      state <= nxt;
      irq_q <= fire_irq;
      req_q <= req;
      if (load) begin
        is_wr_q <= cmd_write;
        err_q   <= 1'b0;
      end else if (set_err) begin
        err_q <= 1'b1;
      end
    end
  end

  // R5
  write_tail_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_XFER && last_word && is_wr_q) |=> (stat_bsy && !stat_drq));

  // R9
  error_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && core_err) |=> (stat_err && irq && !stat_bsy && !stat_drq));

  // R11
  busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && state == ST_WAIT && !core_done && !core_err) |=>
      ($stable(cur_addr) && $stable(sector_count) && $stable(xfer_is_write)));

  // R3
  irq_outside_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !word_ready);
endmodule

// File: tb/ata_xfer_seq_tb.sv
module ata_xfer_seq_tb;
  localparam int ADDR_W = 28;
  localparam int CNT_W  = 8;
  localparam int WORDS  = 256;
  localparam int SETTLE = 2;
  localparam int LAT    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [CNT_W-1:0] cmd_count = '0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic word_valid = 1'b0;
  logic word_ready, core_req, xfer_is_write;
  logic core_done = 1'b0, core_err = 1'b0;
  logic stat_bsy, stat_drq, stat_err, irq;
  logic [CNT_W-1:0] sector_count;
  logic [ADDR_W-1:0] cur_addr;

  always #4 clk = ~clk;

  ata_xfer_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WORDS(WORDS), .SETTLE(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_count(cmd_count), .cmd_addr(cmd_addr), .word_valid(word_valid),
    .word_ready(word_ready), .core_req(core_req), .xfer_is_write(xfer_is_write),
    .core_done(core_done), .core_err(core_err), .stat_bsy(stat_bsy),
    .stat_drq(stat_drq), .stat_err(stat_err), .irq(irq),
    .sector_count(sector_count), .cur_addr(cur_addr)
  );

  int checks = 0;
  int failures = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // host and core models
  bit host_en = 1'b0, gappy = 1'b0, toggle = 1'b0;
  bit err_en = 1'b0;
  logic [ADDR_W-1:0] err_addr = '0;
  bit pending = 1'b0;
  int lat_cnt = 0;

  always @(posedge clk) begin
    #1;
    toggle = ~toggle;
    word_valid = host_en && (!gappy || toggle);
    core_done = 1'b0;
    core_err  = 1'b0;
    if (pending) begin
      if (lat_cnt == 0) begin
        pending = 1'b0;
        if (err_en && cur_addr == err_addr) core_err = 1'b1;
        else core_done = 1'b1;
      end else lat_cnt--;
    end
    if (core_req) begin
      pending = 1'b1;
      lat_cnt = LAT;
    end
  end

  // observation counters, written only here
  int irq_cnt = 0, irq_drq = 0, req_cnt = 0, fall_bsy = 0, words = 0, settle_run = 0;
  bit last_irq_idle = 1'b0, prev_drq = 1'b0, prev_bsy = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (irq) begin
        irq_cnt++;
        if (stat_drq) irq_drq++;
        last_irq_idle = !stat_bsy && !stat_drq;
      end
      if (core_req) req_cnt++;
      if (word_valid && word_ready) words++;
      if (stat_drq && stat_bsy) settle_run++;
      if (stat_drq && !stat_bsy && prev_bsy && prev_drq) begin
        // R7
        check(settle_run == SETTLE, "R7 busy cycles after DRQ", settle_run, SETTLE);
        settle_run = 0;
      end
      if (prev_drq && !stat_drq) begin
        // R6
        check(words == WORDS, "R6 words per sector", words, WORDS);
        words = 0;
        if (stat_bsy) fall_bsy++;
      end
      prev_drq = stat_drq;
      prev_bsy = stat_bsy;
    end
  end

  task automatic issue(input bit wr, input int cnt, input logic [ADDR_W-1:0] a);
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_write = wr; cmd_count = CNT_W'(cnt); cmd_addr = a;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (stat_bsy || stat_drq) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    // R1
    check(!stat_bsy && !stat_drq && !stat_err && !irq, "R1 flags after reset",
          {stat_bsy, stat_drq, stat_err, irq}, 0);
    check(!core_req && !word_ready, "R1 req/ready after reset", {core_req, word_ready}, 0);
    check(sector_count == 0 && cur_addr == 0, "R1 regs after reset", cur_addr, 0);
  endtask

  task automatic t_read(input int n, input logic [ADDR_W-1:0] a, input bit gap);
    int i0 = irq_cnt, d0 = irq_drq, r0 = req_cnt;
    int sectors = (n == 0) ? 256 : n;
    gappy = gap; host_en = 1'b1;
    issue(1'b0, n, a);
    wait_idle();
    host_en = 1'b0;
    // R3
    check(irq_cnt - i0 == sectors, "R3 read irq count", irq_cnt - i0, sectors);
    check(irq_drq - d0 == sectors, "R3 read irq with DRQ", irq_drq - d0, sectors);
    // R12
    check(req_cnt - r0 == sectors, "R12 read core requests", req_cnt - r0, sectors);
    // R8 R2
    check(cur_addr == a + ADDR_W'(sectors), "R8 R2 read final address", cur_addr, a + sectors);
    check(sector_count == 0, "R8 read final count", sector_count, 0);
    check(!stat_err, "R3 read no error", stat_err, 0);
  endtask

  task automatic t_write(input int n, input logic [ADDR_W-1:0] a);
    int i0 = irq_cnt, d0 = irq_drq, r0 = req_cnt, f0 = fall_bsy;
    gappy = 1'b0; host_en = 1'b1;
    issue(1'b1, n, a);
    wait_idle();
    host_en = 1'b0;
    // R4
    check(irq_drq - d0 == n - 1, "R4 write irq with DRQ", irq_drq - d0, n - 1);
    check(irq_cnt - i0 == n, "R4 write irq count", irq_cnt - i0, n);
    // R5
    check(fall_bsy - f0 == n, "R5 DRQ fall with busy", fall_bsy - f0, n);
    check(last_irq_idle, "R5 final irq with busy clear", last_irq_idle, 1);
    // R12
    check(req_cnt - r0 == n, "R12 write core requests", req_cnt - r0, n);
    // R8
    check(cur_addr == a + ADDR_W'(n), "R8 write final address", cur_addr, a + n);
    check(sector_count == 0, "R8 write final count", sector_count, 0);
  endtask

  task automatic t_error(input bit wr, input int n, input int k, input logic [ADDR_W-1:0] a);
    int i0 = irq_cnt, d0 = irq_drq;
    err_en = 1'b1; err_addr = a + ADDR_W'(k);
    gappy = 1'b0; host_en = 1'b1;
    issue(wr, n, a);
    wait_idle();
    host_en = 1'b0; err_en = 1'b0;
    // R9
    check(stat_err, "R9 error flag", stat_err, 1);
    check(cur_addr == a + ADDR_W'(k), "R9 failing address", cur_addr, a + k);
    check(sector_count == CNT_W'(n - k), "R9 remaining count", sector_count, n - k);
    check(irq_cnt - i0 == k + 1, "R9 irq count", irq_cnt - i0, k + 1);
    check(irq_drq - d0 == k, "R9 irq with DRQ", irq_drq - d0, k);
    check(last_irq_idle, "R9 final irq idle", last_irq_idle, 1);
  endtask

  task automatic t_err_clear();
    host_en = 1'b1;
    issue(1'b0, 1, 28'h40);
    @(negedge clk);
    // R10
    check(!stat_err && stat_bsy, "R10 error cleared on new command", stat_err, 0);
    wait_idle();
    host_en = 1'b0;
  endtask

  task automatic t_ignore();
    logic [ADDR_W-1:0] a_snap;
    logic [CNT_W-1:0] c_snap;
    int i0 = irq_cnt;
    host_en = 1'b0;
    issue(1'b0, 2, 28'h300);
    @(negedge clk);
    while (!word_ready) @(negedge clk);
    a_snap = cur_addr; c_snap = sector_count;
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_count = 8'd9; cmd_addr = 28'hABC;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    @(negedge clk);
    // R11
    check(cur_addr == a_snap && sector_count == c_snap, "R11 regs held", cur_addr, a_snap);
    check(!xfer_is_write, "R11 direction held", xfer_is_write, 0);
    host_en = 1'b1;
    wait_idle();
    host_en = 1'b0;
    check(cur_addr == 28'h302 && irq_cnt - i0 == 2, "R11 original command finished",
          cur_addr, 28'h302);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_read(3, 28'h100, 1'b0);
    t_read(2, 28'h200, 1'b1);
    t_write(1, 28'h500);
    t_write(3, 28'h600);
    t_error(1'b0, 5, 2, 28'h700);
    t_err_clear();
    t_error(1'b1, 4, 1, 28'h800);
    t_ignore();
    t_read(0, 28'hFF00, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule